// File: doc/BRIEF.md
# Octal Operate Microinstruction Register Unit

This block is the register side of a small microcoded display controller. It holds a 7-bit horizontal position counter (X), a vertical position counter (Y) whose width is a parameter, a 7-bit accumulator (AC) and a 2-bit ROM bank register. It also holds four single-bit state flags: mode, X8, cursor and video. An 8-bit opcode, written in octal, arrives together with one of three strobes: first operate, second operate or I/O. Each strobe selects its own table of register actions. Opcode bits 6:4 pick the entry in that table. A table acts only when its own enable pattern is present in the opcode.

The registers update on the rising clock edge that follows the strobe. All register values and flags are visible on the outputs. The I/O strobe also produces a combinational request for the sequencer's flag-test flip-flop. The program counter unit can advance the bank register through its own increment input. A bank increment from that input and one from the opcode in the same cycle count as a single step.

Top module: `opreg_unit`

## Requirements
- R1: A synchronous active-high reset clears X, Y, AC, the ROM bank, and the mode, X8, cursor and video flags to zero.
- R2: With `stb_first` high, opcode bit 3 = 1 and bit 7 = 0, bits 6:4 act as follows. 0 clears X and Y. 1 toggles X8. 2 increments X and decrements Y. 3 increments X. 4 clears AC. 5 sets mode. 6 clears X. 7 clears mode.
- R3: With `stb_second` high, opcode bit 2 = 1 and bit 7 = 0, bits 6:4 act as follows. 0 decrements both X and Y. 1 increments AC, and 2 does the same. 3 increments Y. 4 decrements Y. 5 increments the ROM bank. 6 decrements X. 7 decrements AC.
- R4: With `stb_io` high and opcode bits 7 and 3:0 all zero, bits 6:4 act as follows. 0 sets cursor. 1 sets video. 2 loads Y from the low Y_W bits of `buf_data`. 4 clears cursor and video. 7 clears Y. Entries 3, 5 and 6 change nothing.
- R5: A strobe whose enable pattern is absent (bit 3 for first, bit 2 for second, bits 7 and 3:0 zero for I/O) leaves every register unchanged.
- R6: X and AC wrap modulo 128. Y wraps modulo 2^Y_W, in both directions.
- R7: The ROM bank wraps from 3 to 0. `pc_bank_inc` advances it by one. If `pc_bank_inc` and a second-operate entry 5 occur in the same cycle, the bank advances by exactly one.
- R8: `flag_test_set` is high in the same cycle whenever `stb_io` is high with opcode bit 0 = 1 and bit 7 = 0, independent of the other strobes. Otherwise it is low.
- R9: If several strobes are high together, only one table acts: first operate wins over second operate, which wins over I/O.
- R10: With no strobe and no `pc_bank_inc`, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Microinstruction byte |
| stb_first | input | 1 | First-operate strobe |
| stb_second | input | 1 | Second-operate strobe |
| stb_io | input | 1 | I/O strobe |
| buf_data | input | 8 | Buffer byte for the Y load |
| pc_bank_inc | input | 1 | Bank increment request from the PC unit |
| x_out | output | 7 | X counter |
| y_out | output | Y_W | Y counter |
| ac_out | output | 7 | Accumulator |
| bank_out | output | 2 | ROM bank |
| mode_out | output | 1 | Mode flag |
| x8_out | output | 1 | X8 flag |
| cursor_out | output | 1 | Cursor flag |
| video_out | output | 1 | Video flag |
| flag_test_set | output | 1 | Request to set the flag-test flip-flop |

## Verification
The bench drives X and AC through 127 and Y downward through 0. A counter sized one bit too wide or too narrow would miss the wrap and show 128 or a stale value. It fires strobes with the enable bit missing or bit 7 set, where a decoder that ignores the gating would change registers. It also tests the do-nothing I/O entries 3, 5 and 6. It raises two strobes together on opcodes that enable both tables, so a design without priority would move X and Y in the same cycle. It also raises both bank increment sources at once, where an adder that sums them would step the bank by two.

// File: rtl/opreg_pkg.sv
package opreg_pkg;

    localparam int OPW = 8;
    localparam int XW  = 7;
    localparam int AW  = 7;
    localparam int BKW = 2;

    typedef logic [2:0] sel_t;

    typedef struct packed {
        logic x_clr;
        logic x_inc;
        logic x_dec;
        logic y_clr;
        logic y_inc;
        logic y_dec;
        logic y_load;
        logic ac_clr;
        logic ac_inc;
        logic ac_dec;
        logic bank_inc;
        logic x8_tgl;
        logic mode_set;
        logic mode_clr;
        logic cur_set;
        logic cur_clr;
        logic vid_set;
        logic vid_clr;
    } ctl_t;

    function automatic logic first_enabled(logic [OPW-1:0] op);
        return op[3] && !op[7];
    endfunction

    function automatic logic second_enabled(logic [OPW-1:0] op);
        return op[2] && !op[7];
    endfunction

    function automatic logic io_enabled(logic [OPW-1:0] op);
        return (op & 8'h8F) == 8'h00;
    endfunction

    function automatic ctl_t first_table(sel_t s);
        ctl_t c = '0;
        case (s)
            3'd0: begin c.x_clr = 1'b1; c.y_clr = 1'b1; end
            3'd1: c.x8_tgl = 1'b1;
            3'd2: begin c.x_inc = 1'b1; c.y_dec = 1'b1; end
            3'd3: c.x_inc = 1'b1;
            3'd4: c.ac_clr = 1'b1;
            3'd5: c.mode_set = 1'b1;
            3'd6: c.x_clr = 1'b1;
            default: c.mode_clr = 1'b1;
        endcase
        return c;
    endfunction

    function automatic ctl_t second_table(sel_t s);
        ctl_t c = '0;
        case (s)
            3'd0: begin c.x_dec = 1'b1; c.y_dec = 1'b1; end
            3'd1, 3'd2: c.ac_inc = 1'b1;
            3'd3: c.y_inc = 1'b1;
            3'd4: c.y_dec = 1'b1;
            3'd5: c.bank_inc = 1'b1;
            3'd6: c.x_dec = 1'b1;
            default: c.ac_dec = 1'b1;
        endcase
        return c;
    endfunction

    function automatic ctl_t io_table(sel_t s);
        ctl_t c = '0;
        case (s)
            3'd0: c.cur_set = 1'b1;
            3'd1: c.vid_set = 1'b1;
            3'd2: c.y_load = 1'b1;
            3'd4: begin c.cur_clr = 1'b1; c.vid_clr = 1'b1; end
            3'd7: c.y_clr = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/opreg_decoder.sv
module opreg_decoder
    import opreg_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    input  logic           stb_first,
    input  logic           stb_second,
    input  logic           stb_io,
    output ctl_t           ctl,
    output logic           flag_req
);

    sel_t sel;
    assign sel = opcode[6:4];

    always_comb begin
        ctl = '0;
        if (stb_first) begin
            if (first_enabled(opcode)) ctl = first_table(sel);
        end else if (stb_second) begin
            if (second_enabled(opcode)) ctl = second_table(sel);
        end else if (stb_io) begin
            if (io_enabled(opcode)) ctl = io_table(sel);
        end
    end

    assign flag_req = stb_io && opcode[0] && !opcode[7];

    // R9
    always_comb begin
        x_single_action_chk: assert ($onehot0({ctl.x_clr, ctl.x_inc, ctl.x_dec}));
    end

endmodule

// File: rtl/opreg_wrap_ctr.sv
module opreg_wrap_ctr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)                q <= '0;
        else if (clr)           q <= '0;
        else if (ld)            q <= ld_val;
        else if (inc && !dec)   q <= q + ONE;
        else if (dec && !inc)   q <= q - ONE;
    end

    // R6
    count_up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !clr && !ld) |=> (q == $past(q) + ONE));

    // R6
    count_down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !clr && !ld) |=> (q == $past(q) - ONE));

endmodule

// File: rtl/opreg_flags.sv
module opreg_flags
    import opreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    output logic mode,
    output logic x8,
    output logic cursor,
    output logic video
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= 1'b0;
            x8     <= 1'b0;
            cursor <= 1'b0;
            video  <= 1'b0;
        end else begin
            if (ctl.mode_set)      mode <= 1'b1;
            else if (ctl.mode_clr) mode <= 1'b0;
            if (ctl.x8_tgl)        x8 <= !x8;
            if (ctl.cur_set)       cursor <= 1'b1;
            else if (ctl.cur_clr)  cursor <= 1'b0;
            if (ctl.vid_set)       video <= 1'b1;
            else if (ctl.vid_clr)  video <= 1'b0;
        end
    end

    // R4
    video_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(video) |-> $past(ctl.vid_set));

    // R2
    x8_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.x8_tgl |=> (x8 != $past(x8)));

endmodule

// File: rtl/opreg_unit.sv
module opreg_unit
    import opreg_pkg::*;
#(
    parameter int Y_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     opcode,
    input  logic           stb_first,
    input  logic           stb_second,
    input  logic           stb_io,
    input  logic [7:0]     buf_data,
    input  logic           pc_bank_inc,
    output logic [6:0]     x_out,
    output logic [Y_W-1:0] y_out,
    output logic [6:0]     ac_out,
    output logic [1:0]     bank_out,
    output logic           mode_out,
    output logic           x8_out,
    output logic           cursor_out,
    output logic           video_out,
    output logic           flag_test_set
);

    ctl_t ctl;
    logic bank_step;

    opreg_decoder u_dec (
        .opcode     (opcode),
        .stb_first  (stb_first),
        .stb_second (stb_second),
        .stb_io     (stb_io),
        .ctl        (ctl),
        .flag_req   (flag_test_set)
    );

    opreg_wrap_ctr #(.W(XW)) u_x (
        .clk (clk), .rst (rst),
        .clr (ctl.x_clr), .ld (1'b0), .ld_val ('0),
        .inc (ctl.x_inc), .dec (ctl.x_dec),
        .q   (x_out)
    );

    opreg_wrap_ctr #(.W(Y_W)) u_y (
        .clk (clk), .rst (rst),
        .clr (ctl.y_clr), .ld (ctl.y_load), .ld_val (buf_data[Y_W-1:0]),
        .inc (ctl.y_inc), .dec (ctl.y_dec),
        .q   (y_out)
    );

    opreg_wrap_ctr #(.W(AW)) u_ac (
        .clk (clk), .rst (rst),
        .clr (ctl.ac_clr), .ld (1'b0), .ld_val ('0),
        .inc (ctl.ac_inc), .dec (ctl.ac_dec),
        .q   (ac_out)
    );

    assign bank_step = ctl.bank_inc || pc_bank_inc;

    opreg_wrap_ctr #(.W(BKW)) u_bank (
        .clk (clk), .rst (rst),
        .clr (1'b0), .ld (1'b0), .ld_val ('0),
        .inc (bank_step), .dec (1'b0),
        .q   (bank_out)
    );

    opreg_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .mode   (mode_out),
        .x8     (x8_out),
        .cursor (cursor_out),
        .video  (video_out)
    );

    // R7
    bank_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_bank_inc && stb_second && !stb_first && opcode == 8'h54)
        |=> (bank_out == $past(bank_out) + 2'd1));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb_first && !stb_second && !stb_io && !pc_bank_inc)
        |=> ($stable(x_out) && $stable(y_out) && $stable(ac_out) && $stable(bank_out)
             && $stable(mode_out) && $stable(x8_out) && $stable(cursor_out)
             && $stable(video_out)));

    // R8
    flag_req_chk: assert property (@(posedge clk) disable iff (rst)
        flag_test_set |-> (stb_io && !opcode[7]));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (bank_out == 2'd0 && !video_out && x_out == 7'd0 && ac_out == 7'd0));

endmodule

// File: tb/opreg_unit_tb.sv
module opreg_unit_tb;

    localparam int YW = 5;
    localparam int YMOD = 1 << YW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     opcode = 8'h00;
    logic           stb_first = 1'b0, stb_second = 1'b0, stb_io = 1'b0;
    logic [7:0]     buf_data = 8'h00;
    logic           pc_bank_inc = 1'b0;
    logic [6:0]     x_out, ac_out;
    logic [YW-1:0]  y_out;
    logic [1:0]     bank_out;
    logic           mode_out, x8_out, cursor_out, video_out, flag_test_set;

    always #2 clk = ~clk;

    opreg_unit #(.Y_W(YW)) u_dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .stb_first(stb_first), .stb_second(stb_second), .stb_io(stb_io),
        .buf_data(buf_data), .pc_bank_inc(pc_bank_inc),
        .x_out(x_out), .y_out(y_out), .ac_out(ac_out), .bank_out(bank_out),
        .mode_out(mode_out), .x8_out(x8_out), .cursor_out(cursor_out),
        .video_out(video_out), .flag_test_set(flag_test_set)
    );

    typedef struct {
        int x, y, ac, bank;
        bit mode, x8, cur, vid, flag;
        string tag;
    } item_t;

    item_t model;
    item_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic string fmt(int x, int y, int ac, int bank, bit m, bit x8, bit c, bit v, bit f);
        return $sformatf("x=%0d y=%0d ac=%0d bank=%0d mode=%0b x8=%0b cur=%0b vid=%0b flag=%0b",
                         x, y, ac, bank, m, x8, c, v, f);
    endfunction

    function automatic item_t step(item_t s, bit [7:0] op, bit f, bit sc, bit io,
                                   bit [7:0] bd, bit pci);
        item_t n = s;
        bit [2:0] k = op[6:4];
        bit bank_op = 0;
        if (f) begin
            if (op[3] && !op[7]) begin
                case (k)
                    0: begin n.x = 0; n.y = 0; end
                    1: n.x8 = !s.x8;
                    2: begin n.x = (s.x + 1) % 128; n.y = (s.y + YMOD - 1) % YMOD; end
                    3: n.x = (s.x + 1) % 128;
                    4: n.ac = 0;
                    5: n.mode = 1;
                    6: n.x = 0;
                    7: n.mode = 0;
                endcase
            end
        end else if (sc) begin
            if (op[2] && !op[7]) begin
                case (k)
                    0: begin n.x = (s.x + 127) % 128; n.y = (s.y + YMOD - 1) % YMOD; end
                    1, 2: n.ac = (s.ac + 1) % 128;
                    3: n.y = (s.y + 1) % YMOD;
                    4: n.y = (s.y + YMOD - 1) % YMOD;
                    5: bank_op = 1;
                    6: n.x = (s.x + 127) % 128;
                    7: n.ac = (s.ac + 127) % 128;
                endcase
            end
        end else if (io) begin
            if (op[7] == 0 && op[3:0] == 0) begin
                case (k)
                    0: n.cur = 1;
                    1: n.vid = 1;
                    2: n.y = bd % YMOD;
                    4: begin n.cur = 0; n.vid = 0; end
                    7: n.y = 0;
                    default: ;
                endcase
            end
        end
        if (bank_op || pci) n.bank = (s.bank + 1) % 4;
        return n;
    endfunction

    task automatic drive(bit [7:0] op, bit f, bit sc, bit io, bit [7:0] bd, bit pci, string tag);
        item_t e;
        @(negedge clk);
        opcode = op; stb_first = f; stb_second = sc; stb_io = io;
        buf_data = bd; pc_bank_inc = pci;
        e = step(model, op, f, sc, io, bd, pci);
        e.flag = io && op[0] && !op[7];
        e.tag = tag;
        exp_q.push_back(e);
        model = e;
    endtask

    task automatic idle();
        drive(8'h00, 0, 0, 0, 8'h00, 0, "R10");
    endtask

    function automatic bit [7:0] mk(int sel, int low);
        return {1'b0, 3'(sel), 4'(low)};
    endfunction

    always @(posedge clk) begin
        item_t e;
        #1;
        if (!rst && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (x_out != e.x || y_out != e.y || ac_out != e.ac || bank_out != e.bank ||
                mode_out != e.mode || x8_out != e.x8 || cursor_out != e.cur ||
                video_out != e.vid || flag_test_set != e.flag) begin
                fails++;
                $display("FAIL %s: actual %s expected %s", e.tag,
                    fmt(x_out, y_out, ac_out, bank_out, mode_out, x8_out, cursor_out, video_out, flag_test_set),
                    fmt(e.x, e.y, e.ac, e.bank, e.mode, e.x8, e.cur, e.vid, e.flag));
            end
        end
    end

    task automatic check_reset();
        @(negedge clk);
        opcode = 0; stb_first = 0; stb_second = 0; stb_io = 0; pc_bank_inc = 0;
        rst = 1;
        @(negedge clk);
        checks++;
        if (x_out != 0 || y_out != 0 || ac_out != 0 || bank_out != 0 || mode_out ||
            x8_out || cursor_out || video_out) begin
            fails++;
            $display("FAIL R1: actual %s expected all zero",
                fmt(x_out, y_out, ac_out, bank_out, mode_out, x8_out, cursor_out, video_out, 0));
        end
        rst = 0;
        model = '{0, 0, 0, 0, 0, 0, 0, 0, 0, ""};
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        // R2 first-operate table
        drive(mk(5, 8), 1, 0, 0, 0, 0, "R2");
        drive(mk(1, 8), 1, 0, 0, 0, 0, "R2");
        drive(mk(3, 8), 1, 0, 0, 0, 0, "R2");
        drive(mk(2, 8), 1, 0, 0, 0, 0, "R2");
        drive(mk(1, 9), 1, 0, 0, 0, 0, "R2");
        drive(mk(7, 8), 1, 0, 0, 0, 0, "R2");
        drive(mk(6, 8), 1, 0, 0, 0, 0, "R2");
        drive(mk(0, 8), 1, 0, 0, 0, 0, "R2");
        // R6 X wrap through 127
        for (int i = 0; i < 130; i++) drive(mk(3, 8), 1, 0, 0, 0, 0, "R6");
        // R6 AC wrap up and down
        for (int i = 0; i < 130; i++) drive(mk(1, 4), 0, 1, 0, 0, 0, "R6");
        drive(mk(4, 8), 1, 0, 0, 0, 0, "R2");
        drive(mk(7, 4), 0, 1, 0, 0, 0, "R6");
        // R3 second-operate table and Y wrap
        drive(mk(4, 4), 0, 1, 0, 0, 0, "R6");
        drive(mk(3, 4), 0, 1, 0, 0, 0, "R3");
        drive(mk(0, 4), 0, 1, 0, 0, 0, "R3");
        drive(mk(6, 4), 0, 1, 0, 0, 0, "R3");
        drive(mk(2, 4), 0, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 40; i++) drive(mk(3, 5), 0, 1, 0, 0, 0, "R6");
        // R7 bank
        for (int i = 0; i < 5; i++) drive(mk(5, 4), 0, 1, 0, 0, 0, "R7");
        drive(8'h00, 0, 0, 0, 0, 1, "R7");
        drive(mk(5, 4), 0, 1, 0, 0, 1, "R7");
        drive(mk(5, 4), 0, 1, 0, 0, 1, "R7");
        // R4 I/O table
        drive(mk(0, 0), 0, 0, 1, 0, 0, "R4");
        drive(mk(1, 0), 0, 0, 1, 0, 0, "R4");
        drive(mk(2, 0), 0, 0, 1, 8'hAB, 0, "R4");
        drive(mk(3, 0), 0, 0, 1, 0, 0, "R4");
        drive(mk(5, 0), 0, 0, 1, 0, 0, "R4");
        drive(mk(6, 0), 0, 0, 1, 0, 0, "R4");
        drive(mk(4, 0), 0, 0, 1, 0, 0, "R4");
        drive(mk(2, 0), 0, 0, 1, 8'h13, 0, "R4");
        drive(mk(7, 0), 0, 0, 1, 0, 0, "R4");
        // R8 flag request
        drive(8'h21, 0, 0, 1, 0, 0, "R8");
        drive(8'h81, 0, 0, 1, 0, 0, "R8");
        drive(8'h01, 1, 0, 1, 0, 0, "R8");
        drive(8'h20, 0, 0, 1, 8'h05, 0, "R8");
        // R5 gating
        drive(8'h37, 1, 0, 0, 0, 0, "R5");
        drive(8'hB8, 1, 0, 0, 0, 0, "R5");
        drive(8'h3B, 0, 1, 0, 0, 0, "R5");
        drive(8'hB4, 0, 1, 0, 0, 0, "R5");
        drive(8'h02, 0, 0, 1, 0, 0, "R5");
        drive(8'h90, 0, 0, 1, 0, 0, "R5");
        // R9 priority
        drive(8'h3C, 1, 1, 0, 0, 0, "R9");
        drive(8'h4C, 1, 1, 1, 0, 0, "R9");
        drive(8'h10, 0, 1, 1, 0, 0, "R9");
        drive(8'h34, 0, 1, 1, 0, 0, "R9");
        // R10 idle hold
        repeat (3) idle();
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            bit [7:0] op = 8'($urandom);
            bit f  = ($urandom % 3) == 0;
            bit sc = ($urandom % 3) == 0;
            bit io = ($urandom % 3) == 0;
            drive(op, f, sc, io, 8'($urandom), ($urandom % 4) == 0, "R10");
        end
        idle();
        check_reset();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule